// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block sequences a unipolar dual-slope analog-to-digital conversion. It drives the switches around an external integrator and comparator and uses one binary counter for two jobs: timing a fixed integration of the input, then measuring how long the reference takes to bring the integrator back to zero. A conversion has three parts. First the integrator is zeroed. Then the signal is integrated for exactly 2^N clocks. Finally the negative reference is integrated until the comparator reports that the integrator output has crossed zero.

The final count is the input averaged over the fixed window, scaled by 2^N divided by the reference. Because the same clock and the same capacitor act in both phases, the count does not depend on the RC product or on the clock period. Choosing the fixed window as one mains period cancels hum. The comparator output is asynchronous to the sequencer and passes through a synchronizer of SYNC_STAGES flops, which is 2 by default.

The result leaves the block as a valid/ready stream. `res_valid` also serves as end-of-conversion. Once `res_valid` rises, `res_data` and `res_ovr` hold steady until a cycle in which `res_valid` and `res_ready` are both high. In the cycle after that transfer the sequencer is idle again. A pending result therefore back-pressures the converter: no new conversion can start until the result has been taken. `res_ready` has no effect while `res_valid` is low.

Top module: `dsadc_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `int_reset`, `integrate`, `sel_ref`, `res_valid`, `res_ovr` are 0 and `res_data` is 0.
- R2: When `convert` is sampled high in idle, `int_reset` is 1 for max(`hold_cycles`,1) consecutive cycles, starting the next cycle. `integrate` is 0 throughout.
- R3: Right after the zeroing phase, `integrate`=1 with `sel_ref`=0 (signal selected) for exactly 2^N consecutive cycles.
- R4: Next, `integrate`=1 with `sel_ref`=1 (reference selected). Let M be the number of these cycles before the first one in which `cmp_in` is low. The phase lasts M+SYNC_STAGES+1 cycles and the result is M, as a straight binary N-bit value.
- R5: The result depends only on the integrated sum over the fixed window. An input that alternates between two levels gives the same count as its mean.
- R6: If M would reach 2^N, the reference phase ends after 2^N+SYNC_STAGES+1 cycles, with `res_data` all ones and `res_ovr`=1. Otherwise `res_ovr`=0.
- R7: If `cmp_in` is already low when the reference phase starts (zero input), the phase lasts one cycle and the result is 0.
- R8: `res_valid` rises when the reference phase ends. While `res_ready` is 0, `res_valid`, `res_data` and `res_ovr` stay stable. After a cycle with both high, `res_valid` is 0.
- R9: `convert` has no effect from the start of the zeroing phase until the result has been transferred. It does not restart or lengthen any phase, and it is not remembered.
- R10: `res_data` and `res_ovr` change only when a conversion ends. During a conversion they keep the previous result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convert | input | 1 | Start command, sampled in idle |
| hold_cycles | input | HOLD_W | Zeroing length in clocks (0 acts as 1) |
| cmp_in | input | 1 | Comparator, high while integrator output is above zero |
| int_reset | output | 1 | Closes the integrator reset switch |
| sel_ref | output | 1 | Input switch: 0 signal, 1 negative reference |
| integrate | output | 1 | Connects the selected input to the integrator |
| res_valid | output | 1 | Result valid / end of conversion |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | CNT_W | Conversion count, straight binary |
| res_ovr | output | 1 | Run-down exceeded full scale |

## Verification
On every cycle, the assertions check several properties. The zeroing switch and the integration enable are never on together. The signal window closes only from the counter's top value. A zeroing phase ends only on its last hold count. A stalled result stays frozen. An overrange result is all ones. No zeroing phase begins while the sequencer is busy. The bench scenarios show the rest: phase lengths measured at the pins, the count matching a behavioural integrator for several input-to-reference ratios, averaging of an alternating input, the exact overrange and zero-input boundaries, and that a start command issued while busy is dropped and not deferred.

// File: rtl/dsadc_pkg.sv
`timescale 1ns/1ps
package dsadc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ZERO,
    PH_RUNUP,
    PH_RUNDOWN,
    PH_OFFER
  } phase_t;
endpackage

// File: rtl/dsadc_sync.sv
`timescale 1ns/1ps
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/dsadc_counter.sv
`timescale 1ns/1ps
module dsadc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = inc && (&cnt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
endmodule

// File: rtl/dsadc_seq.sv
`timescale 1ns/1ps
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int N      = 8,
  parameter int HOLD_W = 4,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convert,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              cmp_s,
  input  logic [N-1:0]      cnt,
  input  logic              wrap,
  input  logic              accept,
  output phase_t            phase,
  output logic              cnt_clr,
  output logic              cnt_inc,
  output logic              finish,
  output logic [N-1:0]      fin_data,
  output logic              fin_ovr
);
  localparam logic [N-1:0]      LAT_N = N'(LAT);
  localparam logic [HOLD_W-1:0] ONE_H = HOLD_W'(1);

  logic [HOLD_W-1:0] hcnt;
  logic              rd_wrapped;
  logic              over;

  // overrange: count has passed 2^N and the latency tail is used up
  assign over     = (phase == PH_RUNDOWN) && rd_wrapped && (cnt == LAT_N);
  assign finish   = (phase == PH_RUNDOWN) && (over || !cmp_s);
  assign fin_ovr  = over;
  always_comb begin
    if (over)                         fin_data = '1;
    else if (!rd_wrapped && cnt < LAT_N) fin_data = '0;
    else                              fin_data = cnt - LAT_N;
  end

  assign cnt_clr = (phase == PH_ZERO) || ((phase == PH_RUNUP) && wrap);
  assign cnt_inc = (phase == PH_RUNUP) || ((phase == PH_RUNDOWN) && !finish);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      hcnt       <= '0;
      rd_wrapped <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (convert) begin
          phase      <= PH_ZERO;
          hcnt       <= (hold_cycles == '0) ? ONE_H : hold_cycles;
          rd_wrapped <= 1'b0;
        end
        PH_ZERO: begin
          if (hcnt == ONE_H) phase <= PH_RUNUP;
          else               hcnt  <= hcnt - 1'b1;
        end
        PH_RUNUP:   if (wrap) phase <= PH_RUNDOWN;
        PH_RUNDOWN: begin
          if (finish)    phase      <= PH_OFFER;
          else if (wrap) rd_wrapped <= 1'b1;
        end
        PH_OFFER:   if (accept) phase <= PH_IDLE;
        default:    phase <= PH_IDLE;
      endcase
    end
  end

  // R3: signal window closes only from the counter's top value
  p_runup_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUNDOWN && $past(phase) == PH_RUNUP) |-> $past(cnt) == '1);
  // R2: zeroing leaves only on its final hold count
  p_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUNUP && $past(phase) == PH_ZERO) |-> $past(hcnt) == ONE_H);
  // R9: a busy sequencer never re-enters zeroing
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUNUP || phase == PH_RUNDOWN || phase == PH_OFFER) |=> phase != PH_ZERO);
endmodule

// File: rtl/dsadc_result.sv
`timescale 1ns/1ps
module dsadc_result #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         finish,
  input  logic [N-1:0] fin_data,
  input  logic         fin_ovr,
  input  logic         res_ready,
  output logic         res_valid,
  output logic [N-1:0] res_data,
  output logic         res_ovr,
  output logic         accept
);
  assign accept = res_valid && res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_ovr   <= 1'b0;
    end else if (finish) begin
      res_valid <= 1'b1;
      res_data  <= fin_data;
      res_ovr   <= fin_ovr;
    end else if (accept) begin
      res_valid <= 1'b0;
    end
  end

  // R8: stalled result is frozen
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_ovr)));
  // R6: overrange flag implies full-scale code
  p_ovr_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_ovr |-> (res_data == '1));
endmodule

// File: rtl/dsadc_ctrl.sv
`timescale 1ns/1ps
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int HOLD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convert,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              cmp_in,
  output logic              int_reset,
  output logic              sel_ref,
  output logic              integrate,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CNT_W-1:0]  res_data,
  output logic              res_ovr
);
  phase_t             phase;
  logic               cmp_s;
  logic [CNT_W-1:0]   cnt;
  logic               wrap, cnt_clr, cnt_inc, finish, fin_ovr, accept;
  logic [CNT_W-1:0]   fin_data;

  dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_in), .q(cmp_s)
  );

  dsadc_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt), .wrap(wrap)
  );

  dsadc_seq #(.N(CNT_W), .HOLD_W(HOLD_W), .LAT(SYNC_STAGES)) u_seq (
    .clk(clk), .rst_n(rst_n), .convert(convert), .hold_cycles(hold_cycles),
    .cmp_s(cmp_s), .cnt(cnt), .wrap(wrap), .accept(accept), .phase(phase),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .finish(finish),
    .fin_data(fin_data), .fin_ovr(fin_ovr)
  );

  dsadc_result #(.N(CNT_W)) u_res (
    .clk(clk), .rst_n(rst_n), .finish(finish), .fin_data(fin_data),
    .fin_ovr(fin_ovr), .res_ready(res_ready), .res_valid(res_valid),
    .res_data(res_data), .res_ovr(res_ovr), .accept(accept)
  );

  assign int_reset = (phase == PH_ZERO);
  assign integrate = (phase == PH_RUNUP) || (phase == PH_RUNDOWN);
  assign sel_ref   = (phase == PH_RUNDOWN);

  // R2: zeroing switch and integration never overlap
  p_switch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_reset, integrate}));
  // R10: result changes only as a conversion is reported
  p_res_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_data) |-> $rose(res_valid));
endmodule

// File: tb/dsadc_ctrl_bench.sv
`timescale 1ns/1ps
module dsadc_ctrl_bench;
  localparam int N    = 8;
  localparam int HW   = 4;
  localparam int SYN  = 2;
  localparam int FULL = 1 << N;
  localparam int NV   = 8;
  // xa, xb, reference, hold
  localparam int VEC [NV][4] = '{
    '{1, 1, 2, 1}, '{5, 5, 7, 3}, '{9, 9, 10, 0}, '{255, 255, 256, 15},
    '{1, 1, 256, 2}, '{2, 2, 3, 5}, '{2, 6, 9, 1}, '{7, 7, 8, 4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic convert = 1'b0;
  logic [HW-1:0] hold_cycles = '0;
  logic cmp_in, int_reset, sel_ref, integrate, res_valid, res_ovr;
  logic res_ready = 1'b0;
  logic [N-1:0] res_data;

  int errors = 0, checks = 0, cyc = 0;
  int v = 0, xa = 0, xb = 0, rr = 1;
  bit alt = 1'b0;

  always #4 clk = ~clk;

  dsadc_ctrl #(.CNT_W(N), .HOLD_W(HW), .SYNC_STAGES(SYN)) u_dsadc_ctrl (
    .clk(clk), .rst_n(rst_n), .convert(convert), .hold_cycles(hold_cycles),
    .cmp_in(cmp_in), .int_reset(int_reset), .sel_ref(sel_ref),
    .integrate(integrate), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_ovr(res_ovr)
  );

  // behavioural integrator: grows with the signal, falls with the reference
  always @(posedge clk) begin
    if (int_reset) begin
      v <= 0; alt <= 1'b0;
    end else if (integrate) begin
      if (sel_ref) v <= v - rr;
      else begin
        v <= v + (alt ? xb : xa);
        alt <= ~alt;
      end
    end
  end
  assign cmp_in = (v > 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int a, input int b, input int r, input int h, input int poke);
    int nr, nu, nd, s, m, expd, exprd, heff;
    bit ovr;
    logic [N-1:0] prev;
    xa = a; xb = b; rr = r;
    hold_cycles = HW'(h);
    prev = res_data;
    s = (FULL / 2) * (a + b);
    m = (s + r - 1) / r;
    ovr = (m >= FULL);
    expd = ovr ? FULL - 1 : m;
    exprd = (s == 0) ? 1 : (ovr ? FULL + SYN + 1 : m + SYN + 1);
    heff = (h == 0) ? 1 : h;
    nr = 0; nu = 0; nd = 0;
    @(negedge clk) convert = 1'b1;
    @(negedge clk) convert = 1'b0;
    for (int i = 0; i < 5000 && !res_valid; i++) begin
      convert = (i == poke);
      if (int_reset) nr++;
      if (integrate && !sel_ref) nu++;
      if (integrate && sel_ref) begin
        if (nd == 0) check(res_data == prev, "R10 result held during conversion", res_data, prev);
        nd++;
      end
      @(negedge clk);
    end
    convert = 1'b0;
    check(nr == heff, "R2 zeroing length", nr, heff);
    check(nu == FULL, "R3 signal window length", nu, FULL);
    check(nd == exprd, ovr ? "R6 reference phase length" : "R4 reference phase length", nd, exprd);
    check(res_data == N'(expd), s == 0 ? "R7 zero result" : (a != b ? "R5 averaged result" : "R4 result"), res_data, expd);
    check(res_ovr == ovr, "R6 overrange flag", res_ovr, ovr);
    // back-pressure with a start command poked while the result waits
    prev = res_data;
    for (int i = 0; i < 3; i++) begin
      convert = 1'b1;
      @(negedge clk);
      check(res_valid && res_data == prev, "R8 stalled result stable", res_data, prev);
      check(!int_reset && !integrate, "R9 start ignored while result pending", int_reset, 0);
    end
    convert = 1'b0; res_ready = 1'b1;
    @(negedge clk) res_ready = 1'b0;
    check(!res_valid, "R8 valid drops after transfer", res_valid, 0);
    @(negedge clk);
    check(!int_reset, "R9 start not remembered", int_reset, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!int_reset && !integrate && !sel_ref && !res_valid && res_data == 0 && !res_ovr,
          "R1 outputs in reset", {int_reset, integrate, sel_ref, res_valid, res_ovr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!int_reset && !integrate && !res_valid && res_data == 0,
          "R1 outputs after release", {int_reset, integrate, res_valid}, 0);

    for (int k = 0; k < NV; k++)
      run_conv(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3], -1);

    // corner: overrange exactly at 2^N, then zero input
    run_conv(1, 1, 1, 1, -1);
    run_conv(0, 0, 5, 2, -1);
    // R9: start command poked mid-zeroing and mid-window
    run_conv(3, 3, 4, 6, 2);
    run_conv(3, 3, 5, 1, 100);

    // R1: reset in the middle of a reference phase
    xa = 1; xb = 1; rr = 2; hold_cycles = 1;
    @(negedge clk) convert = 1'b1;
    @(negedge clk) convert = 1'b0;
    repeat (270) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!int_reset && !integrate && !sel_ref && !res_valid && res_data == 0,
          "R1 mid-run reset", {int_reset, integrate, sel_ref, res_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule